// File: doc/BRIEF.md
# PWM Output Mute and Validity Sequencer

This block sits between a PCM-to-PWM modulator and the pins that drive the power stages of a stereo digital amplifier. It decides, cycle by cycle, whether each differential PWM pair carries modulator data, a silent 50% duty square wave, or a static safe pattern. It also decides whether the per-channel VALID flags tell the power stages to switch. The modulator itself is outside the block. It is seen only as one P-side data bit per pair and a one-cycle pulse that marks each PWM period boundary.

The sequencer has three main states. In the holding state the outputs are in hard mute: every P output is low, every M output is high and VALID is low. After reset and power-down are released and the clocks are healthy, an initialization timer of `INIT_CYCLES` system clocks runs, and then normal operation begins. In normal operation the active-low mute input selects either pass-through of the modulator bits or quiet mute. Quiet mute is a zero-signal waveform in which P and M toggle in complement at 50% duty. Switching into or out of quiet mute takes place only on a period boundary. A missing clock or a clock phase error sends the block back to hard mute, and it initializes again once the fault clears.

The reset and power-down inputs take effect asynchronously and are released through two-flop synchronizers. The block enters power-down when both of them are low, and it reports that state on `sleep`. If power-down alone is low, the block holds hard mute and does not start initialization.

Top module: `pwm_mute_seq`

## Requirements
- R1: Whenever the block is not in normal operation (reset, power-down, initialization or a clock fault), every bit of `pwm_p` is 0, every bit of `pwm_m` is 1 and every bit of `valid` is 0.
- R2: A low level on `rst_n` forces the R1 pattern at once, without any clock edge.
- R3: `sleep` goes to 1 at once when `rst_n` and `pdn_n` are both low. It stays 0 while only one of them is low. After either input returns high, it clears on the second rising clock edge.
- R4: When `rst_n` and `pdn_n` are both released high between clock edges with `clk_ok`=1 and `phase_err`=0, `valid` stays 0 through rising edge INIT_CYCLES+2 and is 1 after rising edge INIT_CYCLES+3.
- R5: In normal operation with pass-through selected, `pwm_p` equals `pwm_in` and `pwm_m` equals its bitwise complement in the same cycle.
- R6: In normal operation with `mute_n`=0, all bits of `pwm_p` follow one common waveform that is 1 for PWM_PERIOD/2 cycles of each PWM_PERIOD-cycle period, `pwm_m` is its complement, and `valid` remains 1.
- R7: The selection between quiet mute and pass-through changes only at a rising edge where `pwm_tick` is 1. The first period after initialization is always quiet. A change of `mute_n` therefore takes effect within PWM_PERIOD+3 clock edges.
- R8: `clk_ok`=0 or `phase_err`=1, sampled at a rising edge, gives the R1 pattern after that edge.
- R9: After the fault is removed between edges, `valid` is 0 through rising edge INIT_CYCLES and is 1 after rising edge INIT_CYCLES+1.
- R10: While the R1 pattern holds, changes on `pwm_in` and `mute_n` have no effect on `pwm_p`, `pwm_m` or `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down request, active low |
| mute_n | input | 1 | 0 selects quiet mute, 1 selects pass-through |
| clk_ok | input | 1 | Audio clocks present |
| phase_err | input | 1 | Audio clock phase error |
| pwm_tick | input | 1 | One-cycle pulse at each PWM period boundary |
| pwm_in | input | NCH*NPAIR | P-side modulator bit for each pair |
| pwm_p | output | NCH*NPAIR | Positive output of each pair |
| pwm_m | output | NCH*NPAIR | Negative output of each pair |
| valid | output | NCH | Per-channel output-valid flag |
| sleep | output | 1 | Power-down state |

## Verification
The asynchronous results, namely hard mute on reset and `sleep` on power-down, are checked one nanosecond after the input changes, with no clock edge in between. The pass-through result is combinational and is checked one nanosecond after `pwm_in` is driven. Every other result is sampled on falling edges, after a number of rising edges computed from the requirements. For `sleep` release that is two edges. For the first VALID rise it is INIT_CYCLES+3 edges: two synchronizer stages, one edge to enter initialization and INIT_CYCLES edges of counting. After a fault clears it is INIT_CYCLES+1 edges. Each of these boundaries is checked on both sides, one cycle before the edge and one cycle after it. Checks of mute selection wait two full periods so that the synchronizer and the next boundary have both passed, and the 50% duty is then measured by counting over exactly one period.

// File: rtl/pwm_mute_seq.sv
module pwm_mute_seq #(
  parameter int NCH         = 2,
  parameter int NPAIR       = 2,
  parameter int INIT_CYCLES = 500000,
  parameter int PWM_PERIOD  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pdn_n,
  input  logic                   mute_n,
  input  logic                   clk_ok,
  input  logic                   phase_err,
  input  logic                   pwm_tick,
  input  logic [NCH*NPAIR-1:0]   pwm_in,
  output logic [NCH*NPAIR-1:0]   pwm_p,
  output logic [NCH*NPAIR-1:0]   pwm_m,
  output logic [NCH-1:0]         valid,
  output logic                   sleep
);
  localparam int W    = NCH*NPAIR;
  localparam int ICW  = $clog2(INIT_CYCLES + 1);
  localparam int PCW  = $clog2(PWM_PERIOD + 1);
  localparam int HALF = PWM_PERIOD / 2;

  typedef enum logic [1:0] {S_HOLD, S_INIT, S_RUN} st_t;

  st_t            st;
  logic [ICW-1:0] icnt;
  logic [PCW-1:0] pcnt;
  logic           go1, go2, mu1, mu2, sl1, sl2, quiet;
  logic           en_ok, pd_req, healthy, qwave, in_run, in_init;

  assign en_ok   = rst_n & pdn_n;
  assign pd_req  = ~rst_n & ~pdn_n;
  assign healthy = clk_ok & ~phase_err;
  assign in_run  = (st == S_RUN);
  assign in_init = (st == S_INIT);

  always_ff @(posedge clk or negedge en_ok)
    if (!en_ok) {go1, go2} <= 2'b00;
    else        {go1, go2} <= {1'b1, go1};

  always_ff @(posedge clk or negedge en_ok)
    if (!en_ok) {mu1, mu2} <= 2'b11;
    else        {mu1, mu2} <= {mute_n, mu1};

  always_ff @(posedge clk or posedge pd_req)
    if (pd_req) {sl1, sl2} <= 2'b11;
    else        {sl1, sl2} <= {1'b0, sl1};

  assign sleep = sl2;

  always_ff @(posedge clk or negedge en_ok)
    if (!en_ok) begin
      st   <= S_HOLD;
      icnt <= '0;
    end else begin
      case (st)
        S_HOLD: if (go2 && healthy) begin
          st   <= S_INIT;
          icnt <= '0;
        end
        S_INIT:
          if (!healthy)                             st   <= S_HOLD;
          else if (icnt == ICW'(INIT_CYCLES - 1))   st   <= S_RUN;
          else                                      icnt <= icnt + 1'b1;
        S_RUN:  if (!healthy) st <= S_HOLD;
        default: st <= S_HOLD;
      endcase
    end

  always_ff @(posedge clk or negedge en_ok)
    if (!en_ok)                           pcnt <= '0;
    else if (pwm_tick)                    pcnt <= '0;
    else if (pcnt != PCW'(PWM_PERIOD-1))  pcnt <= pcnt + 1'b1;

  assign qwave = (pcnt < PCW'(HALF));

  always_ff @(posedge clk or negedge en_ok)
    if (!en_ok)        quiet <= 1'b1;
    else if (!in_run)  quiet <= 1'b1;
    else if (pwm_tick) quiet <= ~mu2;

  assign pwm_p = !in_run ? '0 : (quiet ? {W{qwave}}  : pwm_in);
  assign pwm_m = !in_run ? '1 : (quiet ? {W{~qwave}} : ~pwm_in);
  assign valid = {NCH{in_run}};
endmodule

module pwm_mute_seq_chk #(
  parameter int W   = 4,
  parameter int NCH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_ok,
  input logic          phase_err,
  input logic          pwm_tick,
  input logic [W-1:0]  pwm_in,
  input logic [W-1:0]  pwm_p,
  input logic [W-1:0]  pwm_m,
  input logic [NCH-1:0] valid,
  input logic          sleep,
  input logic          in_run,
  input logic          in_init,
  input logic          quiet
);
  AST_HARD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == '0) |-> (pwm_p == '0 && pwm_m == '1)); // R1
  AST_VALID_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == '0) || (valid == '1)); // R1
  AST_SLEEP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (valid == '0)); // R3
  AST_RISE_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid[0]) |-> $past(in_init)); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !quiet) |-> (pwm_p == pwm_in && pwm_m == ~pwm_in)); // R5
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid != '0) |-> (pwm_m == ~pwm_p)); // R6
  AST_MUTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && $past(in_run) && !$past(pwm_tick)) |-> $stable(quiet)); // R7
  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_ok || phase_err) |=> (valid == '0)); // R8
endmodule

bind pwm_mute_seq pwm_mute_seq_chk #(.W(NCH*NPAIR), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .phase_err(phase_err),
  .pwm_tick(pwm_tick), .pwm_in(pwm_in), .pwm_p(pwm_p), .pwm_m(pwm_m),
  .valid(valid), .sleep(sleep), .in_run(in_run), .in_init(in_init),
  .quiet(quiet)
);

// File: tb/tb_pwm_mute_seq.sv
`timescale 1ns/1ps
module tb_pwm_mute_seq;
  localparam int NCH = 2, NPAIR = 2, W = NCH*NPAIR;
  localparam int N = 20, PER = 8;

  logic clk = 0, rst_n, pdn_n, mute_n, clk_ok, phase_err, tick;
  logic [W-1:0] pwm_in, pwm_p, pwm_m;
  logic [NCH-1:0] valid;
  logic sleep;
  int errors = 0, checks = 0, tcnt = 0;

  pwm_mute_seq #(.NCH(NCH), .NPAIR(NPAIR), .INIT_CYCLES(N), .PWM_PERIOD(PER)) dut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .mute_n(mute_n), .clk_ok(clk_ok),
    .phase_err(phase_err), .pwm_tick(tick), .pwm_in(pwm_in), .pwm_p(pwm_p),
    .pwm_m(pwm_m), .valid(valid), .sleep(sleep));

  always #5 clk = ~clk;

  initial begin
    tick = 0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1) % PER;
      tick = (tcnt == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_hard(input string req);
    chk(pwm_p == '0, req, pwm_p, 0);
    chk(pwm_m == '1, req, pwm_m, {W{1'b1}});
    chk(valid == '0, req, valid, 0);
  endtask

  task automatic t_reset_state;
    #1;
    chk(sleep == 1'b1, "R3", sleep, 1);
    chk_hard("R1");
  endtask

  task automatic t_power_up;
    @(negedge clk);
    rst_n = 1; pdn_n = 1;
    cyc(1); chk(sleep == 1'b1, "R3", sleep, 1);
    cyc(1); chk(sleep == 1'b0, "R3", sleep, 0);
    pwm_in = 4'hA; mute_n = 0;
    cyc(N);
    chk_hard("R10");
    mute_n = 1;
    cyc(1); chk(valid == '1, "R4", valid, 3);
  endtask

  task automatic t_pass;
    logic [W-1:0] pats [4] = '{4'h0, 4'hF, 4'h5, 4'hC};
    cyc(2*PER);
    foreach (pats[i]) begin
      @(negedge clk); pwm_in = pats[i]; #1;
      chk(pwm_p == pats[i], "R5", pwm_p, pats[i]);
      chk(pwm_m == ~pats[i], "R5", pwm_m, ~pats[i]);
    end
  endtask

  task automatic t_quiet;
    int highs = 0;
    bit bad = 0;
    @(negedge clk); mute_n = 0; pwm_in = 4'h6;
    cyc(PER + 3);
    chk(pwm_p == '0 || pwm_p == '1, "R7", pwm_p, 0);
    cyc(PER);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pwm_p[0]) highs++;
      if (pwm_m != ~pwm_p || !(pwm_p == '0 || pwm_p == '1) || valid != '1) bad = 1;
    end
    chk(highs == PER/2, "R6", highs, PER/2);
    chk(!bad, "R6", bad, 0);
    @(negedge clk); mute_n = 1;
    cyc(PER + 3);
    pwm_in = 4'h9; #1;
    chk(pwm_p == 4'h9, "R7", pwm_p, 9);
  endtask

  task automatic t_fault(input bit use_phase);
    @(negedge clk);
    if (use_phase) phase_err = 1; else clk_ok = 0;
    cyc(1); chk_hard("R8");
    cyc(3);
    if (use_phase) phase_err = 0; else clk_ok = 1;
    cyc(N); chk(valid == '0, "R9", valid, 0);
    cyc(1); chk(valid == '1, "R9", valid, 3);
  endtask

  task automatic t_async_reset;
    @(negedge clk); #2;
    rst_n = 0; #1;
    chk_hard("R2");
    chk(sleep == 1'b0, "R3", sleep, 0);
    pwm_in = 4'hF; mute_n = 0;
    cyc(3); #1;
    chk_hard("R10");
    @(negedge clk); mute_n = 1; rst_n = 1;
    cyc(N + 2); chk(valid == '0, "R4", valid, 0);
    cyc(1); chk(valid == '1, "R4", valid, 3);
  endtask

  task automatic t_power_down;
    @(negedge clk); pdn_n = 0; #1;
    chk(sleep == 1'b0, "R3", sleep, 0);
    chk_hard("R1");
    #2; rst_n = 0; #1;
    chk(sleep == 1'b1, "R3", sleep, 1);
    chk_hard("R1");
  endtask

  initial begin
    rst_n = 0; pdn_n = 0; mute_n = 1; clk_ok = 1; phase_err = 0; pwm_in = '0;
    fork
      begin
        t_reset_state();
        t_power_up();
        t_pass();
        t_quiet();
        t_fault(0);
        t_fault(1);
        t_async_reset();
        t_power_down();
      end
      begin
        #2_000_000;
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule